// File: doc/BRIEF.md
# Closed-Loop Transmit Power Regulator

This block sits in the external power transmitter of an inductive link. The remote side reports its rectifier voltage back over the data link as a digitized sample. The sample carries half of the rectifier voltage. The block compares that sample with a programmable target and nudges an 8-bit code up or down by a programmable step. A DAC turns the code into the power amplifier supply, spanning 2 V at code 0 to 12 V at code 255. A low reading raises the code and a high reading lowers it. A reading within one LSB of the target leaves the code alone and raises a locked flag.

Updates happen only on a slow periodic tick, nominally 100 Hz. A received sample is captured whenever its valid strobe fires, and the most recent one is consumed at the next tick. A tick that finds no new sample since the previous tick changes nothing. With a 10-bit sample at 4 mV per LSB, a nominal 3.2 V rectifier corresponds to a target of 400.

Top module: `pwr_loop_ctrl`

## Requirements
- R1: On a tick with a fresh sample more than 1 LSB below the target, code_o rises by step_i at that clock edge and locked_o goes low.
- R2: On a tick with a fresh sample more than 1 LSB above the target, code_o falls by step_i at that clock edge and locked_o goes low.
- R3: On a tick with a fresh sample within target-1 to target+1 inclusive, code_o is unchanged and locked_o goes high.
- R4: Stepping up saturates at 255 and never wraps to a small value.
- R5: Stepping down saturates at 0 and never wraps to a large value.
- R6: A tick with no valid sample since the previous tick leaves code_o and locked_o unchanged.
- R7: While rst_ni is low, code_o is 0 (lowest supply) and locked_o is 0.
- R8: Without a tick, code_o never changes. The sample used at a tick is the last one strobed since the previous tick, and a sample strobed in the tick cycle itself takes precedence.
- R9: Closed around a plant with a fixed coupling factor, the loop reaches lock with the fed-back sample within 1 LSB of the target, and it re-locks after a step change in coupling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Loop update tick, one cycle wide |
| sample_vld_i | input | 1 | Received sample strobe |
| sample_i | input | 10 | Received half-rectifier-voltage sample |
| target_i | input | 10 | Target value for the sample |
| step_i | input | 4 | Code step size per update |
| code_o | output | 8 | DAC code setting the amplifier supply |
| locked_o | output | 1 | Last update fell inside the deadband |

## Verification
The bench builds the block with its defaults: a 10-bit sample, a 4-bit step, an 8-bit code and a deadband of one LSB. It drives ticks every few clocks instead of at 100 Hz, so hundreds of loop updates fit in a short run. A step of 15 reaches both saturation rails within a few ticks. A step of 1 around a code-to-voltage plant with coupling factors of 0.30 and then 0.40 settles the loop at two well-separated codes. The 10-bit sample range lets targets of 0 and 1023 pin the loop against each rail.

// File: rtl/pwr_loop_pkg.sv
package pwr_loop_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } dir_e;
endpackage

// File: rtl/pwr_sample_hold.sv
module pwr_sample_hold #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] data_i,
  input  logic         tick_i,
  output logic         fresh_o,
  output logic [W-1:0] data_o
);
  logic         pend_q;
  logic [W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      held_q <= '0;
    end else begin
      if (tick_i)     pend_q <= 1'b0;
      else if (vld_i) pend_q <= 1'b1;
      if (vld_i)      held_q <= data_i;
    end
  end

  // same-cycle strobe wins over the held value
  assign fresh_o = vld_i | pend_q;
  assign data_o  = vld_i ? data_i : held_q;
endmodule

// File: rtl/pwr_err_classify.sv
module pwr_err_classify
  import pwr_loop_pkg::*;
#(
  parameter int W  = 10,
  parameter int DB = 1
) (
  input  logic [W-1:0] sample_i,
  input  logic [W-1:0] target_i,
  output dir_e         dir_o
);
  localparam int DW = W + 2;

  generate
    if (DB == 0) begin : g_exact
      always_comb begin
        if (sample_i < target_i)      dir_o = DIR_UP;
        else if (sample_i > target_i) dir_o = DIR_DOWN;
        else                          dir_o = DIR_HOLD;
      end
    end else begin : g_band
      logic signed [DW-1:0] diff;
      localparam logic signed [DW-1:0] DB_P = DW'(DB);
      localparam logic signed [DW-1:0] DB_N = -DW'(DB);
      assign diff = $signed({2'b00, sample_i}) - $signed({2'b00, target_i});
      always_comb begin
        if (diff < DB_N)      dir_o = DIR_UP;
        else if (diff > DB_P) dir_o = DIR_DOWN;
        else                  dir_o = DIR_HOLD;
      end
    end
  endgenerate
endmodule

// File: rtl/pwr_sat_stepper.sv
module pwr_sat_stepper
  import pwr_loop_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  dir_e              dir_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic [CODE_W-1:0] code_q, code_d, up_nxt, dn_nxt;
  logic [CODE_W:0]   step_x, up_sum;

  assign step_x = {{(CODE_W + 1 - STEP_W){1'b0}}, step_i};
  assign up_sum = {1'b0, code_q} + step_x;
  assign up_nxt = up_sum[CODE_W] ? CODE_MAX : up_sum[CODE_W-1:0];
  assign dn_nxt = (step_x > {1'b0, code_q}) ? '0 : code_q - step_x[CODE_W-1:0];

  always_comb begin
    code_d = code_q;
    if (en_i) begin
      unique case (dir_i)
        DIR_UP:   code_d = up_nxt;
        DIR_DOWN: code_d = dn_nxt;
        default:  code_d = code_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/pwr_loop_ctrl.sv
module pwr_loop_ctrl
  import pwr_loop_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int STEP_W   = 4,
  parameter int CODE_W   = 8,
  parameter int DB       = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                sample_vld_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] target_i,
  input  logic [STEP_W-1:0]   step_i,
  output logic [CODE_W-1:0]   code_o,
  output logic                locked_o
);
  logic                fresh;
  logic [SAMPLE_W-1:0] cur_sample;
  dir_e                dir;
  logic                upd_en;
  logic                locked_q;

  pwr_sample_hold #(.W(SAMPLE_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (sample_vld_i),
    .data_i  (sample_i),
    .tick_i  (tick_i),
    .fresh_o (fresh),
    .data_o  (cur_sample)
  );

  pwr_err_classify #(.W(SAMPLE_W), .DB(DB)) u_cls (
    .sample_i (cur_sample),
    .target_i (target_i),
    .dir_o    (dir)
  );

  assign upd_en = tick_i & fresh;

  pwr_sat_stepper #(.CODE_W(CODE_W), .STEP_W(STEP_W)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (upd_en),
    .dir_i  (dir),
    .step_i (step_i),
    .code_o (code_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     locked_q <= 1'b0;
    else if (upd_en) locked_q <= (dir == DIR_HOLD);
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/pwr_loop_ctrl_chk.sv
module pwr_loop_ctrl_chk #(
  parameter int SAMPLE_W = 10,
  parameter int STEP_W   = 4,
  parameter int CODE_W   = 8,
  parameter int DB       = 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tick_i,
  input logic                sample_vld_i,
  input logic [SAMPLE_W-1:0] sample_i,
  input logic [SAMPLE_W-1:0] target_i,
  input logic [STEP_W-1:0]   step_i,
  input logic [CODE_W-1:0]   code_o,
  input logic                locked_o
);
  localparam logic [SAMPLE_W:0] DB_X     = (SAMPLE_W + 1)'(DB);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic [SAMPLE_W:0] s_x, t_x;
  assign s_x = {1'b0, sample_i};
  assign t_x = {1'b0, target_i};

  assert_hold_no_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(code_o));

  assert_lock_needs_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(tick_i));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && sample_vld_i && (s_x + DB_X < t_x) && code_o == CODE_MAX) |=> code_o == CODE_MAX);

  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && sample_vld_i && (s_x > t_x + DB_X) && code_o == '0) |=> code_o == '0);

  assert_step_bounded_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (((code_o >= $past(code_o)) ? (code_o - $past(code_o))
                                           : ($past(code_o) - code_o))
                <= {{(CODE_W - STEP_W){1'b0}}, $past(step_i)}));

  assert_up_when_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && sample_vld_i && (s_x + DB_X < t_x)) |=> (code_o >= $past(code_o)) && !locked_o);

  assert_down_when_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && sample_vld_i && (s_x > t_x + DB_X)) |=> (code_o <= $past(code_o)) && !locked_o);
endmodule

bind pwr_loop_ctrl pwr_loop_ctrl_chk #(
  .SAMPLE_W (SAMPLE_W),
  .STEP_W   (STEP_W),
  .CODE_W   (CODE_W),
  .DB       (DB)
) u_chk (.*);

// File: tb/sim_pwr_loop_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_loop_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       vld = 1'b0;
  logic [9:0] sample = '0;
  logic [9:0] target = 10'd400;
  logic [3:0] step = 4'd5;
  logic [7:0] code;
  logic       locked;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  int k_pct = 30;
  string cur_req = "R7";

  // behavioural reference state
  int m_code = 0, m_lock = 0, m_pend = 0, m_held = 0;

  always #2.5 clk = ~clk;

  pwr_loop_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sample_vld_i(vld),
    .sample_i(sample), .target_i(target), .step_i(step),
    .code_o(code), .locked_o(locked)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_lock = 0; m_pend = 0; m_held = 0;
    end else begin
      if (tick) begin
        if (vld || m_pend != 0) begin
          int s;
          s = vld ? int'(sample) : m_held;
          if (s < int'(target) - 1) begin
            m_code = m_code + int'(step); if (m_code > 255) m_code = 255; m_lock = 0;
          end else if (s > int'(target) + 1) begin
            m_code = m_code - int'(step); if (m_code < 0) m_code = 0; m_lock = 0;
          end else m_lock = 1;
        end
        m_pend = 0;
      end else if (vld) m_pend = 1;
      if (vld) m_held = int'(sample);
    end
  end

  always @(negedge clk) begin
    cycles++;
    vectors++;
    if (int'(code) != m_code || int'(locked) != m_lock) begin
      miscompares++;
      $display("FAIL %s cycle %0d: code=%0d locked=%0d expected code=%0d locked=%0d",
               cur_req, cycles, code, locked, m_code, m_lock);
    end
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 0; vld = 0;
    end
  endtask

  task automatic strobe(input int s);
    @(negedge clk); tick = 0; vld = 1; sample = 10'(s);
  endtask

  task automatic tick_with(input int s);
    @(negedge clk); tick = 1; vld = 1; sample = 10'(s);
    @(negedge clk); tick = 0; vld = 0;
  endtask

  task automatic bare_tick;
    @(negedge clk); tick = 1; vld = 0;
    @(negedge clk); tick = 0;
  endtask

  // plant: supply mV = 2000 + code*10000/255, rectifier = supply*k, sample LSB = 8 mV of rectifier
  function automatic int plant(input int c);
    int vsup;
    vsup = 2000 + (c * 10000) / 255;
    return ((vsup * k_pct) / 100) / 8;
  endfunction

  task automatic run_loop(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 0; vld = 1; sample = 10'(plant(m_code));
      @(negedge clk); tick = 1; vld = 0;
      @(negedge clk); tick = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    idle(3);
    cur_req = "R7";
    chk("R7 reset code", int'(code), 0);
    chk("R7 reset locked", int'(locked), 0);
    @(negedge clk); rst_n = 1;
    idle(2);

    cur_req = "R1";
    tick_with(100);
    chk("R1 step up by 5", int'(code), 5);
    chk("R1 locked low", int'(locked), 0);

    cur_req = "R8";
    strobe(100); idle(3);
    chk("R8 no tick no change", int'(code), 5);
    strobe(700); idle(1);
    bare_tick;
    chk("R8 latest sample used, R2 down", int'(code), 0);
    tick_with(100);
    strobe(700);
    tick_with(100);
    chk("R8 same-cycle sample wins", int'(code), 10);

    cur_req = "R6";
    bare_tick;
    chk("R6 tick without sample holds", int'(code), 10);

    cur_req = "R3";
    tick_with(401);
    chk("R3 upper edge holds code", int'(code), 10);
    chk("R3 upper edge locks", int'(locked), 1);
    tick_with(399);
    chk("R3 lower edge locks", int'(locked), 1);
    bare_tick;
    chk("R6 lock held without sample", int'(locked), 1);

    cur_req = "R2";
    tick_with(402);
    chk("R2 step down by 5", int'(code), 5);
    chk("R2 locked low", int'(locked), 0);

    cur_req = "R5";
    tick_with(700);
    tick_with(700);
    chk("R5 saturate at 0", int'(code), 0);

    cur_req = "R4";
    step = 4'd15;
    for (int i = 0; i < 20; i++) tick_with(0);
    chk("R4 saturate at 255", int'(code), 255);
    target = 10'd1023;
    tick_with(1000);
    chk("R4 no wrap at top", int'(code), 255);
    target = 10'd0;
    step = 4'd15;
    for (int i = 0; i < 20; i++) tick_with(500);
    cur_req = "R5";
    chk("R5 floor with target 0", int'(code), 0);

    cur_req = "R9";
    target = 10'd400;
    step = 4'd1;
    k_pct = 30;
    run_loop(300);
    chk("R9 locked at k=0.30", int'(locked), 1);
    chk("R9 sample in band at k=0.30", (plant(int'(code)) >= 399 && plant(int'(code)) <= 401) ? 1 : 0, 1);
    k_pct = 40;
    run_loop(300);
    chk("R9 relocked at k=0.40", int'(locked), 1);
    chk("R9 sample in band at k=0.40", (plant(int'(code)) >= 399 && plant(int'(code)) <= 401) ? 1 : 0, 1);

    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule